// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block combines two eight-line interrupt controllers into one sixteen-input system. One controller is the primary and the other the secondary. Lines 0 to 7 go to the primary and lines 8 to 15 go to the secondary. Each controller keeps its own pending, in-service and rotation state. When the secondary has a winning request, the sequencer pulses primary line 2, which serves as the cascade input. The single processor request output follows the primary's winner.

When the processor acknowledges, the sequencer finds the winning line on each level it needs. It marks that line in service, or applies automatic end-of-interrupt when that is enabled. It clears the pending bit of an edge-triggered line and keeps the pending bit of a level-triggered one. One cycle later it returns an 8-bit vector, formed from the programmed base of the controller that owns the line. In the same cycle it reports the acknowledged system line number (0 to 15) with a notify pulse.

An acknowledge with no valid winner still yields a vector, using line 7 of the controller at which the search ran dry. Programming of the configuration, and the bus decode, sit outside this block. Configuration arrives as static inputs.

Top module: `cascade_ack_seq`

## Requirements
- R1: When the secondary has a winning request, primary line 2 becomes pending on the next clock edge and stays pending until acknowledged. The external input on line 2 (bit 2 of `irq_in`) has no effect.
- R2: `int_req` is high exactly when the primary has a winner. A winner is the unmasked pending line with the best priority, whose priority is strictly better than that of every in-service line. Priority counts up from the rotation offset, which is 0 after reset, so line 0 is best after reset. A mask bit of 1 blocks its line.
- R3: An acknowledge sets the in-service bit of the winning line when automatic end-of-interrupt is off. Afterwards, lines of lower priority raise no request, while lines of higher priority still do.
- R4: A line whose `level_sel` bit is 1 is level-triggered. Its pending bit follows the input level and is not cleared by an acknowledge.
- R5: With automatic end-of-interrupt on for a controller (`auto_eoi` bit 0 for the primary, bit 1 for the secondary), the acknowledged line is left out of service. If `rot_aeoi` is also set for that controller, the rotation offset becomes (line + 1) mod 8.
- R6: When the primary winner is line 2 and the secondary has a winner, the secondary is acknowledged as well. The vector is `base_s`*8 + secondary line, and the reported line is the secondary line + 8.
- R7: When the primary winner is line 2 and the secondary has no winner, the vector is `base_s`*8 + 7 and the reported line is 15.
- R8: When the primary has no winner, the vector is `base_m`*8 + 7, the reported line is 7, and no state changes.
- R9: `vec_valid` and `ack_note` are high for exactly one cycle, in the cycle after `ack` is sampled high. `vec` and `ack_sys_line` are valid in that cycle. For a direct primary line, the vector is `base_m`*8 + line.
- R10: With `nested_cascade` set, the primary ignores its own in-service line 2 when it judges the current priority. A further secondary request that beats the one in service can then interrupt.
- R11: After reset nothing is pending or in service. `int_req`, `vec_valid` and `ack_note` are low.
- R12: An edge-triggered line becomes pending only on a 0-to-1 change of its input. A line held high after its acknowledge raises no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request inputs; bits 7:0 primary, 15:8 secondary |
| level_sel | input | 16 | 1 = level-triggered line, 0 = edge-triggered |
| mask | input | 16 | 1 = line masked |
| base_m | input | 5 | Primary vector base (upper five bits) |
| base_s | input | 5 | Secondary vector base (upper five bits) |
| auto_eoi | input | 2 | Automatic end-of-interrupt; bit 0 primary, bit 1 secondary |
| rot_aeoi | input | 2 | Rotate on automatic end-of-interrupt; bit 0 primary, bit 1 secondary |
| nested_cascade | input | 1 | Primary ignores in-service line 2 for priority |
| ack | input | 1 | Processor interrupt acknowledge, one cycle |
| int_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector strobe |
| vec | output | 8 | Returned vector |
| ack_note | output | 1 | Acknowledged-line notify pulse |
| ack_sys_line | output | 4 | Acknowledged system line, 0 to 15 |

## Verification
A table drives single lines, pairs of competing lines, masked requests, secondary requests that race a lower-priority primary line, and no request at all. It separates three acknowledge outcomes: a direct primary acknowledge, a cascaded acknowledge, and a spurious acknowledge at the primary.

Directed sequences cover the remaining behaviour:
- an in-service line that blocks lower lines but not higher ones;
- an edge-triggered line held high, against a level-triggered line held high;
- rotation on automatic end-of-interrupt, which reverses the order of two pending lines;
- special nesting, which lets a second secondary request through while line 2 is in service;
- a secondary request withdrawn after the cascade line has latched, which must yield the secondary spurious vector.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  localparam int CTL_LINES = 8;
  localparam int LINE_W    = $clog2(CTL_LINES);
  localparam int VEC_W     = 8;
  localparam int BASE_W    = VEC_W - LINE_W;
  localparam int SYS_W     = LINE_W + 1;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [BASE_W-1:0] base_t;
  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [SYS_W-1:0]  sys_t;

  localparam line_t SPUR_LINE = line_t'(CTL_LINES - 1);

  typedef enum logic [1:0] {
    ACK_DIRECT,
    ACK_CASCADE,
    ACK_SLAVE_SPUR,
    ACK_MASTER_SPUR
  } ack_kind_e;

  // vector = base * lines + line
  function automatic vec_t form_vector(base_t base, line_t line);
    return {base, line};
  endfunction

  // system line = controller index * lines + line
  function automatic sys_t system_line(logic from_slave, line_t line);
    return {from_slave, line};
  endfunction

  // rotation offset after a rotating auto end-of-interrupt
  function automatic line_t next_offset(line_t line);
    return line + line_t'(1);
  endfunction
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  input  logic [LW-1:0]    rot,
  output logic             found,
  output logic [LW-1:0]    prio,
  output logic [LW-1:0]    line
);
  // scan from worst to best so the best relative priority is kept last
  always_comb begin
    found = 1'b0;
    prio  = '0;
    line  = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      if (req[rot + LW'(p)]) begin
        found = 1'b1;
        prio  = LW'(p);
        line  = rot + LW'(p);
      end
    end
  end
endmodule

// File: rtl/pic_bank.sv
module pic_bank #(
  parameter int LINES     = 8,
  parameter bit HAS_CASC  = 1'b0,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  input  logic             casc_set,
  input  logic [LINES-1:0] level_sel,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] ignore_isr,
  input  logic             auto_eoi,
  input  logic             rot_aeoi,
  input  logic             ack_en,
  input  logic [LW-1:0]    ack_line,
  output logic             win,
  output logic [LW-1:0]    win_line
);
  logic [LINES-1:0] irr_q, last_q, isr_q;
  logic [LINES-1:0] irr_d, last_d, isr_d;
  logic [LW-1:0]    rot_q;
  logic [LINES-1:0] ack_hit;
  logic [LINES-1:0] pend, busy;
  logic             p_found, c_found;
  logic [LW-1:0]    p_prio, c_prio, p_line, c_line;

  assign ack_hit = ack_en ? (LINES'(1) << ack_line) : '0;
  assign pend    = irr_q & ~mask;
  assign busy    = isr_q & ~ignore_isr;

  pic_prio_pick #(.LINES(LINES)) u_pend_pick (
    .req(pend), .rot(rot_q), .found(p_found), .prio(p_prio), .line(p_line)
  );

  pic_prio_pick #(.LINES(LINES)) u_busy_pick (
    .req(busy), .rot(rot_q), .found(c_found), .prio(c_prio), .line(c_line)
  );

  logic unused_busy_line;
  assign unused_busy_line = ^c_line;

  assign win      = p_found && (!c_found || (p_prio < c_prio));
  assign win_line = p_line;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (HAS_CASC && i == CASC_LINE) begin : g_casc
      // cascade line: edge from the other controller, external pin unused
      logic unused_pin;
      assign unused_pin = raw[i] ^ level_sel[i];
      assign irr_d[i]   = (casc_set && !ack_en) || (irr_q[i] && !ack_hit[i]);
      assign last_d[i]  = 1'b0;
    end else begin : g_ext
      logic rise;
      assign rise      = raw[i] & ~last_q[i];
      assign irr_d[i]  = level_sel[i] ? raw[i] : (rise | (irr_q[i] & ~ack_hit[i]));
      assign last_d[i] = raw[i];
    end
    assign isr_d[i] = ack_hit[i] ? !auto_eoi : isr_q[i];
  end

  if (!HAS_CASC) begin : g_nocasc
    logic unused_casc;
    assign unused_casc = casc_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
      rot_q  <= '0;
    end else begin
      irr_q  <= irr_d;
      last_q <= last_d;
      isr_q  <= isr_d;
      if (ack_en && auto_eoi && rot_aeoi)
        rot_q <= cascade_pkg::next_offset(ack_line);
    end
  end

  // acknowledge is only ever applied to the current winner
  assert_ack_on_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> (win && ack_line == win_line));

  assert_isr_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !auto_eoi) |=> isr_q[$past(ack_line)]);

  assert_aeoi_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && auto_eoi) |=> !isr_q[$past(ack_line)]);

  assert_level_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && level_sel[ack_line] && raw[ack_line] &&
     !(HAS_CASC && ack_line == LW'(CASC_LINE))) |=> irr_q[$past(ack_line)]);

  if (HAS_CASC) begin : g_casc_chk
    assert_casc_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_set && !ack_en) |=> irr_q[CASC_LINE]);
  end
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
  import cascade_pkg::*;
#(
  parameter int CASC_LINE = 2,
  localparam int LINES = CTL_LINES,
  localparam int SYS   = 2 * LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYS-1:0]   irq_in,
  input  logic [SYS-1:0]   level_sel,
  input  logic [SYS-1:0]   mask,
  input  logic [BASE_W-1:0] base_m,
  input  logic [BASE_W-1:0] base_s,
  input  logic [1:0]       auto_eoi,
  input  logic [1:0]       rot_aeoi,
  input  logic             nested_cascade,
  input  logic             ack,
  output logic             int_req,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec,
  output logic             ack_note,
  output logic [SYS_W-1:0] ack_sys_line
);
  logic      m_win, s_win;
  line_t     m_line, s_line;
  logic      m_ack_en, s_ack_en;
  ack_kind_e kind;
  vec_t      vec_d;
  sys_t      sys_d;
  logic [LINES-1:0] m_ignore;

  assign m_ignore = nested_cascade ? (LINES'(1) << CASC_LINE) : '0;

  pic_bank #(.LINES(LINES), .HAS_CASC(1'b1), .CASC_LINE(CASC_LINE)) u_master (
    .clk(clk), .rst_n(rst_n),
    .raw(irq_in[LINES-1:0]), .casc_set(s_win),
    .level_sel(level_sel[LINES-1:0]), .mask(mask[LINES-1:0]),
    .ignore_isr(m_ignore), .auto_eoi(auto_eoi[0]), .rot_aeoi(rot_aeoi[0]),
    .ack_en(m_ack_en), .ack_line(m_line),
    .win(m_win), .win_line(m_line)
  );

  pic_bank #(.LINES(LINES), .HAS_CASC(1'b0), .CASC_LINE(CASC_LINE)) u_slave (
    .clk(clk), .rst_n(rst_n),
    .raw(irq_in[SYS-1:LINES]), .casc_set(1'b0),
    .level_sel(level_sel[SYS-1:LINES]), .mask(mask[SYS-1:LINES]),
    .ignore_isr('0), .auto_eoi(auto_eoi[1]), .rot_aeoi(rot_aeoi[1]),
    .ack_en(s_ack_en), .ack_line(s_line),
    .win(s_win), .win_line(s_line)
  );

  assign int_req = m_win;

  always_comb begin
    if (!m_win)                          kind = ACK_MASTER_SPUR;
    else if (m_line != line_t'(CASC_LINE)) kind = ACK_DIRECT;
    else if (s_win)                      kind = ACK_CASCADE;
    else                                 kind = ACK_SLAVE_SPUR;
  end

  assign m_ack_en = ack && m_win;
  assign s_ack_en = ack && (kind == ACK_CASCADE);

  always_comb begin
    case (kind)
      ACK_DIRECT: begin
        vec_d = form_vector(base_m, m_line);
        sys_d = system_line(1'b0, m_line);
      end
      ACK_CASCADE: begin
        vec_d = form_vector(base_s, s_line);
        sys_d = system_line(1'b1, s_line);
      end
      ACK_SLAVE_SPUR: begin
        vec_d = form_vector(base_s, SPUR_LINE);
        sys_d = system_line(1'b1, SPUR_LINE);
      end
      default: begin
        vec_d = form_vector(base_m, SPUR_LINE);
        sys_d = system_line(1'b0, SPUR_LINE);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid    <= 1'b0;
      ack_note     <= 1'b0;
      vec          <= '0;
      ack_sys_line <= '0;
    end else begin
      vec_valid <= ack;
      ack_note  <= ack;
      if (ack) begin
        vec          <= vec_d;
        ack_sys_line <= sys_d;
      end
    end
  end

  assert_strobe_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (vec_valid && ack_note));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (!vec_valid && !ack_note));

  assert_master_spur_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_req) |=> (vec == form_vector($past(base_m), SPUR_LINE) &&
                           ack_sys_line == sys_t'(CTL_LINES - 1)));

  assert_slave_only_via_casc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack_en |-> (m_ack_en && m_line == line_t'(CASC_LINE)));
endmodule

// File: tb/cascade_ack_seq_test.sv
`timescale 1ns/1ps
module cascade_ack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0, level_sel = '0, mask = '0;
  logic [4:0]  base_m = 5'h01, base_s = 5'h0E;
  logic [1:0]  auto_eoi = '0, rot_aeoi = '0;
  logic        nested_cascade = 1'b0, ack = 1'b0;
  logic        int_req, vec_valid, ack_note;
  logic [7:0]  vec;
  logic [3:0]  ack_sys_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  cascade_ack_seq uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_sel), .mask(mask),
    .base_m(base_m), .base_s(base_s), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
    .nested_cascade(nested_cascade), .ack(ack), .int_req(int_req),
    .vec_valid(vec_valid), .vec(vec), .ack_note(ack_note), .ack_sys_line(ack_sys_line)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; level_sel = '0; mask = '0;
    auto_eoi = '0; rot_aeoi = '0; nested_cascade = 1'b0; ack = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic ack_expect(string tag, int exp_vec, int exp_line);
    do_ack();
    chk({tag, " vector"}, vec, exp_vec);
    chk({tag, " line"}, ack_sys_line, exp_line);
  endtask

  typedef struct packed {
    logic [15:0] irq;
    logic [15:0] msk;
    logic        exp_int;
    logic [7:0]  exp_vec;
    logic [3:0]  exp_line;
  } row_t;

  // base_m = 1 (vectors 0x08..0x0F), base_s = 0x0E (vectors 0x70..0x77)
  localparam row_t ROWS [9] = '{
    '{16'h0001, 16'h0000, 1'b1, 8'h08, 4'd0},   // R2 single line
    '{16'h0030, 16'h0000, 1'b1, 8'h0C, 4'd4},   // R2 lower number wins
    '{16'h0030, 16'h0010, 1'b1, 8'h0D, 4'd5},   // R2 mask removes line 4
    '{16'h0100, 16'h0000, 1'b1, 8'h70, 4'd8},   // R6 cascade line 8
    '{16'h0C80, 16'h0000, 1'b1, 8'h72, 4'd10},  // R6 cascade beats master line 7
    '{16'h0004, 16'h0000, 1'b0, 8'h0F, 4'd7},   // R1 external line 2 ignored, R8
    '{16'h0000, 16'h0000, 1'b0, 8'h0F, 4'd7},   // R8 nothing pending
    '{16'h8000, 16'h8000, 1'b0, 8'h0F, 4'd7},   // R8 masked secondary
    '{16'h0102, 16'h0000, 1'b1, 8'h09, 4'd1}    // R2 line 1 beats cascade line 2
  };

  initial begin
    do_reset();
    chk("R11 int_req after reset", int_req, 0);
    chk("R11 vec_valid after reset", vec_valid, 0);
    chk("R11 ack_note after reset", ack_note, 0);

    for (int r = 0; r < 9; r++) begin
      do_reset();
      irq_in = ROWS[r].irq;
      mask   = ROWS[r].msk;
      wait_cyc(3);
      chk($sformatf("R2/R1 row %0d int_req", r), int_req, ROWS[r].exp_int);
      ack_expect($sformatf("R6/R8/R9 row %0d", r), ROWS[r].exp_vec, ROWS[r].exp_line);
    end

    // R9 strobe length
    do_reset();
    irq_in = 16'h0001; wait_cyc(3);
    do_ack();
    chk("R9 vec_valid high", vec_valid, 1);
    chk("R9 ack_note high", ack_note, 1);
    chk("R9 vector", vec, 8'h08);
    wait_cyc(1);
    chk("R9 vec_valid one cycle", vec_valid, 0);
    chk("R9 ack_note one cycle", ack_note, 0);

    // R3 in-service blocks lower, admits higher
    do_reset();
    irq_in = 16'h0008; wait_cyc(3);
    ack_expect("R3 first", 8'h0B, 3);
    chk("R3 no request after ack", int_req, 0);
    irq_in = 16'h0028; wait_cyc(3);
    chk("R3 lower line blocked", int_req, 0);
    irq_in = 16'h002A; wait_cyc(3);
    chk("R3 higher line requests", int_req, 1);
    ack_expect("R3 higher", 8'h09, 1);

    // R12 edge-triggered held high
    do_reset();
    auto_eoi = 2'b01;
    irq_in = 16'h0010; wait_cyc(3);
    ack_expect("R12 edge", 8'h0C, 4);
    chk("R12 held high no request", int_req, 0);
    irq_in = 16'h0000; wait_cyc(2);
    irq_in = 16'h0010; wait_cyc(2);
    chk("R12 new rise requests", int_req, 1);

    // R4 level-triggered held high
    do_reset();
    auto_eoi = 2'b01; level_sel = 16'h0010;
    irq_in = 16'h0010; wait_cyc(3);
    ack_expect("R4 level first", 8'h0C, 4);
    chk("R4 level still requests", int_req, 1);
    ack_expect("R4 level again", 8'h0C, 4);
    irq_in = 16'h0000; wait_cyc(2);
    chk("R4 level drop withdraws", int_req, 0);

    // R5 rotation on auto end-of-interrupt
    do_reset();
    auto_eoi = 2'b01; rot_aeoi = 2'b01;
    irq_in = 16'h0042; wait_cyc(3);
    ack_expect("R5 first", 8'h09, 1);
    irq_in = 16'h0043; wait_cyc(2);
    ack_expect("R5 rotated order", 8'h0E, 6);
    ack_expect("R5 wraps to line 0", 8'h08, 0);
    chk("R5 nothing left", int_req, 0);

    // R10 special nesting
    do_reset();
    irq_in = 16'h0800; wait_cyc(3);
    ack_expect("R10 first cascade", 8'h73, 11);
    irq_in = 16'h0A00; wait_cyc(3);
    chk("R10 blocked without nesting", int_req, 0);
    nested_cascade = 1'b1; wait_cyc(1);
    chk("R10 allowed with nesting", int_req, 1);
    ack_expect("R10 nested", 8'h71, 9);

    // R7 secondary spurious, R1 cascade line stays latched
    do_reset();
    irq_in = 16'h0200; wait_cyc(3);
    chk("R1 cascade raises int_req", int_req, 1);
    mask = 16'h0200; wait_cyc(2);
    chk("R1 cascade line latched", int_req, 1);
    ack_expect("R7 secondary spurious", 8'h77, 15);
    chk("R7 cascade line cleared", int_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule